// File: doc/BRIEF.md
# Error-Correcting Byte RAM Guard

This block sits between a processor's byte-wide memory port and a synchronous storage array that is 13 bits wide. Every byte written is widened by four Hamming check bits and one overall parity bit. Every word read back is decoded. A single flipped bit anywhere in the 13-bit word is repaired before the byte is returned. Two flipped bits are detected and reported, and the byte is returned as stored.

Data reads that find an error capture the word address and can raise a one-cycle interrupt. Single-bit interrupts are gated by an enable bit. Double-bit interrupts are always raised, and they also set a sticky status flag. Reads marked as instruction fetches are corrected in the same way, but they report nothing.

A small control register port selects a test mode. In test mode a 13-bit inversion mask is XORed into each encoded word before it is stored, so that software can plant faults on purpose. The mode register is guarded by a key register, and the key must be written again before each change of mode.

Top module: `ecc_ram_guard`

## Requirements
- R1: Each write stores a 13-bit word. Bits [7:0] hold the data byte d. Bits [11:8] hold check bits c0..c3, where c0=d0^d1^d3^d4^d6, c1=d0^d2^d3^d5^d6, c2=d1^d2^d3^d7 and c3=d4^d5^d6^d7. Bit 12 makes the XOR of all 13 bits equal zero.
- R2: `mem_rvalid` is high, with the read byte on `mem_rdata`, in the cycle right after a read request is accepted (`mem_req`=1, `mem_we`=0).
- R3: When a single bit of the stored word is wrong, whether a data bit, a check bit or the parity bit, the original byte is returned.
- R4: When the overall parity is correct but the syndrome is non-zero (two bits wrong), the stored byte is returned uncorrected. On a data read this sets the double-error flag (status register 0, bit 0) and raises `err_irq` whatever the enable setting.
- R5: On a data read, a single-bit error raises `err_irq` only when bit 0 of the enable register (address 1) is 1.
- R6: For a data read that finds any error, the error address register (address 2) is loaded with the word address. Any interrupt is a one-cycle pulse in the cycle after `mem_rvalid`.
- R7: A read with `mem_fetch`=1 raises no interrupt, leaves the error address unchanged and does not set the double-error flag.
- R8: The double-error flag stays set until a register write to address 0 with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged.
- R9: With the mode bit set (address 4, bit 0 = 1), each written word is XORed with the 13-bit mask (address 5) before it is stored. With the mode bit clear, the mask has no effect.
- R10: A write to the mode register is ignored unless the key 8'hA5 was written to address 3 beforehand. Address 3 reads back 1 in bit 0 while unlocked.
- R11: Writing any other value to address 3 locks the mode register again. One accepted mode write also locks it again.
- R12: After reset, every register reads 0, and `err_irq` and `mem_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_fetch | input | 1 | Read is an instruction fetch |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 8 | Write byte |
| mem_rdata | output | 8 | Corrected read byte |
| mem_rvalid | output | 1 | Read byte valid |
| reg_sel | input | 1 | Register port select |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
Clean round trips use the bytes 00, FF, A5 and 3C, which show that encoding and decoding agree and that no false error is reported. Faults are planted through the test mode one at a time: in a data bit, a check bit, the parity bit, and in two data bits together. These separate correction of data bits from detection only in the check and parity positions, and separate single errors from double errors. The single-error case is run once with the interrupt enable clear and once with it set, and a double-error word is also read as a fetch, which isolates the gating of the interrupt and of the address capture. Register sequences with no key, the right key, a wrong key and a repeated write check the guard on the mode register.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W  = 8;
  localparam int CHK_W   = 4;
  localparam int WORD_W  = DATA_W + CHK_W + 1;
  localparam int REG_DW  = 16;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;

  typedef enum logic [2:0] {
    RA_STAT = 3'd0,
    RA_IEN  = 3'd1,
    RA_EADR = 3'd2,
    RA_KEY  = 3'd3,
    RA_MODE = 3'd4,
    RA_MASK = 3'd5
  } reg_addr_e;

  // Hamming position (1..12) occupied by each data bit
  function automatic logic [3:0] data_pos(input int i);
    case (i)
      0: data_pos = 4'd3;
      1: data_pos = 4'd5;
      2: data_pos = 4'd6;
      3: data_pos = 4'd7;
      4: data_pos = 4'd9;
      5: data_pos = 4'd10;
      6: data_pos = 4'd11;
      default: data_pos = 4'd12;
    endcase
  endfunction

  function automatic logic [CHK_W-1:0] calc_check(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int k = 0; k < CHK_W; k++) begin
        if (data_pos(i)[k]) c[k] = c[k] ^ d[i];
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  input  logic              inv_en,
  input  logic [WORD_W-1:0] inv_mask,
  output logic [WORD_W-1:0] word_out
);
  logic [CHK_W-1:0]  chk;
  logic [WORD_W-1:0] clean;

  always_comb begin
    chk   = calc_check(data_in);
    clean = {^{chk, data_in}, chk, data_in};
    word_out = inv_en ? (clean ^ inv_mask) : clean;
  end
endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_word;
    if (rd_en) rd_word <= cells[rd_addr];
  end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  output logic [DATA_W-1:0] data_out,
  output logic              err_single,
  output logic              err_double
);
  logic [CHK_W-1:0] syn;
  logic             par_bad;

  always_comb begin
    syn        = calc_check(word_in[DATA_W-1:0]) ^ word_in[DATA_W +: CHK_W];
    par_bad    = ^word_in;
    err_single = par_bad;
    err_double = !par_bad && (syn != '0);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    assign data_out[i] = word_in[i] ^ (par_bad && (syn == data_pos(i)));
  end
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              ev_valid,
  input  logic              ev_fetch,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_single,
  input  logic              ev_double,
  output logic              test_mode,
  output logic [WORD_W-1:0] inv_mask,
  output logic              err_irq
);
  logic              dbl_q, dbl_d;
  logic              ien_q, ien_d;
  logic [ADDR_W-1:0] eadr_q, eadr_d;
  logic              unl_q, unl_d;
  logic              mode_q, mode_d;
  logic [WORD_W-1:0] mask_q, mask_d;
  logic              irq_q, irq_d;
  logic              wr_stat, wr_ien, wr_key, wr_mode, wr_mask;
  logic              data_err;

  always_comb begin
    wr_stat = reg_sel && reg_we && (reg_addr == RA_STAT);
    wr_ien  = reg_sel && reg_we && (reg_addr == RA_IEN);
    wr_key  = reg_sel && reg_we && (reg_addr == RA_KEY);
    wr_mode = reg_sel && reg_we && (reg_addr == RA_MODE);
    wr_mask = reg_sel && reg_we && (reg_addr == RA_MASK);
    data_err = ev_valid && !ev_fetch && (ev_single || ev_double);

    dbl_d = dbl_q;
    if (data_err && ev_double)         dbl_d = 1'b1;
    else if (wr_stat && !reg_wdata[0]) dbl_d = 1'b0;

    ien_d  = wr_ien ? reg_wdata[0] : ien_q;
    eadr_d = data_err ? ev_addr : eadr_q;
    mask_d = wr_mask ? reg_wdata[WORD_W-1:0] : mask_q;

    unl_d  = unl_q;
    mode_d = mode_q;
    if (wr_key) begin
      unl_d = (reg_wdata[7:0] == UNLOCK_KEY);
    end else if (wr_mode && unl_q) begin
      mode_d = reg_wdata[0];
      unl_d  = 1'b0;
    end

    irq_d = ev_valid && !ev_fetch && (ev_double || (ev_single && ien_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q  <= 1'b0;
      ien_q  <= 1'b0;
      eadr_q <= '0;
      unl_q  <= 1'b0;
      mode_q <= 1'b0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      dbl_q  <= dbl_d;
      ien_q  <= ien_d;
      eadr_q <= eadr_d;
      unl_q  <= unl_d;
      mode_q <= mode_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT: reg_rdata[0] = dbl_q;
      RA_IEN:  reg_rdata[0] = ien_q;
      RA_EADR: reg_rdata[ADDR_W-1:0] = eadr_q;
      RA_KEY:  reg_rdata[0] = unl_q;
      RA_MODE: reg_rdata[0] = mode_q;
      RA_MASK: reg_rdata[WORD_W-1:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign test_mode = mode_q;
  assign inv_mask  = mask_q;
  assign err_irq   = irq_q;

  assert_mode_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(unl_q));
  assert_relock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && unl_q && !wr_key) |=> !unl_q);
  assert_irq_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ev_valid));
  assert_fetch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(ev_fetch));
  assert_dbl_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbl_q) |-> irq_q);
  assert_single_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(ev_double)) |-> $past(ien_q));
endmodule

// File: rtl/ecc_ram_guard.sv
module ecc_ram_guard
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic              mem_fetch,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              mem_rvalid,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              err_irq
);
  logic [1:0]        rs_q;
  logic              rst_s;
  logic              wr_go, rd_go;
  logic              rv_q, rv_d;
  logic              fetch_q, fetch_d;
  logic [ADDR_W-1:0] radr_q, radr_d;
  logic [WORD_W-1:0] enc_word, ram_word;
  logic              test_mode;
  logic [WORD_W-1:0] inv_mask;
  logic              dec_single, dec_double;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  always_comb begin
    wr_go   = mem_req && mem_we;
    rd_go   = mem_req && !mem_we;
    rv_d    = rd_go;
    fetch_d = rd_go ? mem_fetch : fetch_q;
    radr_d  = rd_go ? mem_addr  : radr_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rv_q    <= 1'b0;
      fetch_q <= 1'b0;
      radr_q  <= '0;
    end else begin
      rv_q    <= rv_d;
      fetch_q <= fetch_d;
      radr_q  <= radr_d;
    end
  end

  ecc_encoder u_enc (
    .data_in (mem_wdata),
    .inv_en  (test_mode),
    .inv_mask(inv_mask),
    .word_out(enc_word)
  );

  ecc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .wr_en  (wr_go),
    .wr_addr(mem_addr),
    .wr_word(enc_word),
    .rd_en  (rd_go),
    .rd_addr(mem_addr),
    .rd_word(ram_word)
  );

  ecc_decoder u_dec (
    .word_in   (ram_word),
    .data_out  (mem_rdata),
    .err_single(dec_single),
    .err_double(dec_double)
  );

  ecc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .reg_sel  (reg_sel),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ev_valid (rv_q),
    .ev_fetch (fetch_q),
    .ev_addr  (radr_q),
    .ev_single(dec_single),
    .ev_double(dec_double),
    .test_mode(test_mode),
    .inv_mask (inv_mask),
    .err_irq  (err_irq)
  );

  assign mem_rvalid = rv_q;

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_s)
    mem_rvalid |-> $past(mem_req && !mem_we));
endmodule

// File: tb/tb_ecc_ram_guard.sv
module tb_ecc_ram_guard;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_req = 0, mem_we = 0, mem_fetch = 0;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0]    mem_wdata = '0;
  logic [7:0]    mem_rdata;
  logic          mem_rvalid;
  logic          reg_sel = 0, reg_we = 0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          err_irq;

  always #2.5 clk = ~clk;

  ecc_ram_guard #(.ADDR_W(AW)) dut (.*);

  typedef struct { logic [7:0] d; logic irq; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit run = 0, done = 0;
  bit prev_rv = 0, prev_irq = 0;
  string prev_tag = "";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (run) begin
      if (prev_rv) chk({prev_tag, " irq"}, err_irq, prev_irq);
      else if (err_irq) chk("R6 spurious irq", err_irq, 0);
      prev_rv = 0;
      if (mem_rvalid) begin
        if (sb.size() == 0) chk("R2 unexpected rvalid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " data"}, mem_rdata, e.d);
          prev_rv = 1; prev_irq = e.irq; prev_tag = e.tag;
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mwrite(logic [AW-1:0] a, logic [7:0] d);
    mem_req = 1; mem_we = 1; mem_fetch = 0; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic mread(logic [AW-1:0] a, bit f, logic [7:0] d, bit irq, string tag);
    exp_t e;
    e.d = d; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    mem_req = 1; mem_we = 0; mem_fetch = f; mem_addr = a;
    @(negedge clk);
    mem_req = 0; mem_fetch = 0;
  endtask

  task automatic rwrite(logic [2:0] a, logic [15:0] d);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic rcheck(logic [2:0] a, logic [15:0] exp, string tag);
    reg_sel = 1; reg_we = 0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic plant(logic [AW-1:0] a, logic [7:0] d, logic [12:0] m);
    rwrite(3, 16'h00A5); rwrite(4, 16'h0001); rwrite(5, {3'b0, m});
    mwrite(a, d);
    rwrite(3, 16'h00A5); rwrite(4, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R12 reset state
    chk("R12 irq", err_irq, 0);
    chk("R12 rvalid", mem_rvalid, 0);
    for (int i = 0; i < 6; i++) rcheck(i[2:0], 16'h0, "R12 reg");
    run = 1;

    // R1 R2 clean round trips
    mwrite(1, 8'h00); mwrite(2, 8'hFF); mwrite(3, 8'hA5); mwrite(4, 8'h3C);
    mread(1, 0, 8'h00, 0, "R1 00");
    mread(2, 0, 8'hFF, 0, "R1 FF");
    mread(3, 0, 8'hA5, 0, "R2 A5");
    mread(4, 0, 8'h3C, 0, "R2 3C");
    idle(3);

    // R10 mode write without key ignored
    rwrite(4, 16'h0001);
    rcheck(4, 16'h0, "R10 locked");
    // R11 wrong key relocks
    rwrite(3, 16'h00A5);
    rcheck(3, 16'h1, "R10 unlocked");
    rwrite(3, 16'h0011);
    rwrite(4, 16'h0001);
    rcheck(4, 16'h0, "R11 wrong key");
    // R11 accepted write relocks
    rwrite(3, 16'h00A5); rwrite(4, 16'h0001);
    rcheck(4, 16'h1, "R10 mode set");
    rcheck(3, 16'h0, "R11 relocked");
    rwrite(4, 16'h0000);
    rcheck(4, 16'h1, "R11 second write");
    rwrite(3, 16'h00A5); rwrite(4, 16'h0000);

    // R9 mask ignored in normal mode
    rwrite(5, 16'h1FFF);
    mwrite(5, 8'h5A);
    mread(5, 0, 8'h5A, 0, "R9 normal mask");
    idle(3);

    // R5 single data error, interrupt disabled; address still captured (R6)
    plant(10, 8'hC3, 13'h0001);
    mread(10, 0, 8'hC3, 0, "R5 disabled");
    idle(2);
    rcheck(2, 16'd10, "R6 addr single");
    rcheck(0, 16'h0, "R3 no dbl");

    rwrite(1, 16'h0001);
    // R3 data bit 6 flip, irq enabled
    plant(11, 8'h96, 13'h0040);
    mread(11, 0, 8'h96, 1, "R5 enabled");
    idle(2);
    rcheck(2, 16'd11, "R6 addr");
    // R3 check bit flip
    plant(12, 8'h71, 13'h0200);
    mread(12, 0, 8'h71, 1, "R3 check bit");
    // R3 parity bit flip
    plant(13, 8'hE8, 13'h1000);
    mread(13, 0, 8'hE8, 1, "R3 parity bit");
    idle(2);
    rcheck(0, 16'h0, "R3 no dbl flag");

    // R4 double error with enable off
    rwrite(1, 16'h0000);
    plant(20, 8'h4D, 13'h0003);
    mread(20, 1, 8'h4E, 0, "R7 fetch dbl");
    idle(2);
    rcheck(0, 16'h0, "R7 flag untouched");
    rcheck(2, 16'd13, "R7 addr untouched");
    mread(20, 0, 8'h4E, 1, "R4 double");
    idle(2);
    rcheck(0, 16'h1, "R4 flag set");
    rcheck(2, 16'd20, "R4 addr");
    // R8 sticky, write 1 no effect, write 0 clears
    mread(1, 0, 8'h00, 0, "R8 clean read");
    idle(2);
    rcheck(0, 16'h1, "R8 sticky");
    rwrite(0, 16'h0001);
    rcheck(0, 16'h1, "R8 write one");
    rwrite(0, 16'h0000);
    rcheck(0, 16'h0, "R8 cleared");

    // R2 back-to-back reads
    mread(2, 0, 8'hFF, 0, "R2 b2b a");
    mread(3, 0, 8'hA5, 0, "R2 b2b b");
    idle(4);
    chk("R2 queue drained", sb.size(), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule